// File: doc/BRIEF.md
# Processor Status and Mode Register

This block keeps the eight processor condition and mode flags and a separate, hidden emulation bit. Each clock cycle it takes at most one flag command from the instruction sequencer. The commands are: clear or set a group of flags selected by an 8-bit mask, set or clear one named flag, swap carry with the emulation bit, or load the whole byte that was pulled from the stack. When no command is present, per-flag write strobes from the ALU update the flags.

The block reports the full status byte, the emulation bit and the two width selects that the register file and ALU use. While the emulation bit is 1, the two width flags stay at 1 whatever the source of the write. Each time the index width flag changes to 1, the block pulses a strobe for one cycle so that the register file zeroes the upper bytes of both index registers. All results are registered and are visible one cycle after the clock edge that samples the stimulus.

Top module: `psr_unit`

## Requirements
- R1: After reset the status byte is 0x34 (interrupt disable, index width and accumulator width are 1, all other flags are 0). The emulation bit is 1 and the truncation strobe is 0.
- R2: The status bits, from bit 0 upward, are carry, zero, interrupt disable, decimal, index width, accumulator width, overflow, negative. `acc_8bit` always equals bit 5 and `idx_8bit` always equals bit 4 (1 selects 8-bit, 0 selects 16-bit).
- R3: Command code 1 (mask clear) clears every status bit whose `cmd_imm` bit is 1 and leaves the other bits unchanged.
- R4: Command code 2 (mask set) sets every status bit whose `cmd_imm` bit is 1 and leaves the other bits unchanged.
- R5: The single-flag commands are: code 3 clears carry, 4 sets carry, 5 clears interrupt disable, 6 sets interrupt disable, 7 clears decimal, 8 sets decimal, 9 clears overflow. Each one changes only its own flag.
- R6: Command code 10 swaps the carry flag and the emulation bit.
- R7: Command code 11 loads all eight status bits from `cmd_imm`.
- R8: While the emulation bit is 1, bits 5 and 4 stay at 1 after any command or ALU write. Entering emulation forces both bits to 1.
- R9: `idx_trunc` is 1 for exactly the one cycle in which bit 4 has just changed from 0 to 1, and is 0 at all other times.
- R10: With command code 0, each bit i for which `alu_we[i]` is 1 takes the value of `alu_val[i]`. Bits whose strobe is 0 keep their value.
- R11: With a command code from 1 to 11, the ALU strobes are ignored for that whole cycle.
- R12: Codes 12 to 15 are treated as no command, so the ALU strobes apply in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 4 | Command code (0 = none) |
| cmd_imm | input | 8 | Mask for codes 1 and 2, pulled byte for code 11 |
| alu_we | input | 8 | Per-flag write strobes from the ALU |
| alu_val | input | 8 | Flag values from the ALU |
| status | output | 8 | Status byte |
| emu | output | 1 | Emulation bit |
| acc_8bit | output | 1 | Accumulator width select, 1 = 8-bit |
| idx_8bit | output | 1 | Index width select, 1 = 8-bit |
| idx_trunc | output | 1 | One-cycle strobe that zeroes the index high bytes |

## Verification
Every result depends on exactly one register. The status byte, the emulation bit, both width selects and the truncation strobe all reflect a stimulus one cycle after the rising edge that samples it. The driver applies each command on a falling edge and queues the expected result. The monitor removes that item from the queue shortly after the next rising edge, so every comparison falls in the first cycle the result can appear. The strobe is also checked in the following cycle, which confirms that it lasts only one cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int SR_W = 8;

    // flag positions; other blocks decode these bits
    localparam int B_C = 0;
    localparam int B_Z = 1;
    localparam int B_I = 2;
    localparam int B_D = 3;
    localparam int B_X = 4;
    localparam int B_M = 5;
    localparam int B_V = 6;
    localparam int B_N = 7;

    localparam int OP_W = 4;
    localparam logic [OP_W-1:0] OP_NONE = 4'd0;
    localparam logic [OP_W-1:0] OP_MCLR = 4'd1;
    localparam logic [OP_W-1:0] OP_MSET = 4'd2;
    localparam logic [OP_W-1:0] OP_CLC  = 4'd3;
    localparam logic [OP_W-1:0] OP_SEC  = 4'd4;
    localparam logic [OP_W-1:0] OP_CLI  = 4'd5;
    localparam logic [OP_W-1:0] OP_SEI  = 4'd6;
    localparam logic [OP_W-1:0] OP_CLD  = 4'd7;
    localparam logic [OP_W-1:0] OP_SED  = 4'd8;
    localparam logic [OP_W-1:0] OP_CLV  = 4'd9;
    localparam logic [OP_W-1:0] OP_XCE  = 4'd10;
    localparam logic [OP_W-1:0] OP_LOAD = 4'd11;

    localparam logic [SR_W-1:0] RST_STATUS = 8'h34;
    localparam logic            RST_EMU    = 1'b1;

    typedef struct packed {
        logic            is_cmd;
        logic            load;
        logic            xchg;
        logic [SR_W-1:0] set_m;
        logic [SR_W-1:0] clr_m;
    } psr_ctl_t;

    typedef struct packed {
        logic [SR_W-1:0] st;
        logic            emu;
        logic            trunc;
    } psr_state_t;

endpackage

// File: rtl/psr_cmd_dec.sv
module psr_cmd_dec
    import psr_pkg::*;
(
    input  logic [OP_W-1:0] cmd_op,
    input  logic [SR_W-1:0] cmd_imm,
    output psr_ctl_t        ctl
);
    function automatic logic [SR_W-1:0] bit_of(input int pos);
        logic [SR_W-1:0] r;
        r      = '0;
        r[pos] = 1'b1;
        return r;
    endfunction

    always_comb begin
        ctl        = '0;
        ctl.is_cmd = 1'b1;
        case (cmd_op)
            OP_MCLR: ctl.clr_m = cmd_imm;
            OP_MSET: ctl.set_m = cmd_imm;
            OP_CLC:  ctl.clr_m = bit_of(B_C);
            OP_SEC:  ctl.set_m = bit_of(B_C);
            OP_CLI:  ctl.clr_m = bit_of(B_I);
            OP_SEI:  ctl.set_m = bit_of(B_I);
            OP_CLD:  ctl.clr_m = bit_of(B_D);
            OP_SED:  ctl.set_m = bit_of(B_D);
            OP_CLV:  ctl.clr_m = bit_of(B_V);
            OP_XCE:  ctl.xchg  = 1'b1;
            OP_LOAD: ctl.load  = 1'b1;
            default: ctl.is_cmd = 1'b0;
        endcase
    end
endmodule

// File: rtl/psr_alu_merge.sv
module psr_alu_merge
    import psr_pkg::*;
(
    input  logic [SR_W-1:0] cur,
    input  logic [SR_W-1:0] we,
    input  logic [SR_W-1:0] val,
    output logic [SR_W-1:0] merged
);
    for (genvar i = 0; i < SR_W; i++) begin : g_bit
        assign merged[i] = we[i] ? val[i] : cur[i];
    end
endmodule

// File: rtl/psr_width.sv
module psr_width
    import psr_pkg::*;
(
    input  logic [SR_W-1:0] st,
    output logic            acc_8bit,
    output logic            idx_8bit
);
    assign acc_8bit = st[B_M];
    assign idx_8bit = st[B_X];
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      cmd_op,
    input  logic [7:0]      cmd_imm,
    input  logic [7:0]      alu_we,
    input  logic [7:0]      alu_val,
    output logic [7:0]      status,
    output logic            emu,
    output logic            acc_8bit,
    output logic            idx_8bit,
    output logic            idx_trunc
);
    psr_ctl_t        ctl;
    psr_state_t      cur_q, nxt_d;
    logic [SR_W-1:0] alu_st;

    psr_cmd_dec u_dec (
        .cmd_op  (cmd_op),
        .cmd_imm (cmd_imm),
        .ctl     (ctl)
    );

    psr_alu_merge u_alu (
        .cur    (cur_q.st),
        .we     (alu_we),
        .val    (alu_val),
        .merged (alu_st)
    );

    always_comb begin
        nxt_d = cur_q;
        if (ctl.is_cmd) begin
            if (ctl.load) begin
                nxt_d.st = cmd_imm;
            end
            nxt_d.st = (nxt_d.st & ~ctl.clr_m) | ctl.set_m;
            if (ctl.xchg) begin
                nxt_d.emu      = cur_q.st[B_C];
                nxt_d.st[B_C]  = cur_q.emu;
            end
        end else begin
            nxt_d.st = alu_st;
        end
        // emulation pins both width flags to 8-bit
        nxt_d.st[B_M] = nxt_d.st[B_M] | nxt_d.emu;
        nxt_d.st[B_X] = nxt_d.st[B_X] | nxt_d.emu;
        nxt_d.trunc   = nxt_d.st[B_X] & ~cur_q.st[B_X];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= RST_STATUS;
            cur_q.emu   <= RST_EMU;
            cur_q.trunc <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    psr_width u_wid (
        .st       (cur_q.st),
        .acc_8bit (acc_8bit),
        .idx_8bit (idx_8bit)
    );

    assign status    = cur_q.st;
    assign emu       = cur_q.emu;
    assign idx_trunc = cur_q.trunc;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd_op,
    input logic [7:0] cmd_imm,
    input logic [7:0] status,
    input logic       emu,
    input logic       acc_8bit,
    input logic       idx_8bit,
    input logic       idx_trunc
);
    assert_width_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_8bit == status[5]) && (idx_8bit == status[4]));

    assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd1 && !emu) |=> ((status & $past(cmd_imm)) == 8'h00));

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd2) |=> ((status & $past(cmd_imm)) == $past(cmd_imm)));

    assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd10) |=> (emu == $past(status[0]) && status[0] == $past(emu)));

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd11) |=> (status == ($past(cmd_imm) | ($past(emu) ? 8'h30 : 8'h00))));

    assert_emu_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        emu |-> (status[5] && status[4]));

    assert_trunc_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_trunc |-> (idx_8bit && !$past(idx_8bit)));

    assert_trunc_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idx_8bit) |-> idx_trunc);
endmodule

bind psr_unit psr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_op    (cmd_op),
    .cmd_imm   (cmd_imm),
    .status    (status),
    .emu       (emu),
    .acc_8bit  (acc_8bit),
    .idx_8bit  (idx_8bit),
    .idx_trunc (idx_trunc)
);

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_imm = '0;
    logic [7:0] alu_we = '0;
    logic [7:0] alu_val = '0;
    logic [7:0] status;
    logic       emu, acc_8bit, idx_8bit, idx_trunc;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] st;
        logic       em;
        logic       tr;
        string      tag;
    } exp_t;

    exp_t q[$];
    logic [7:0] m_st = 8'h34;
    logic       m_em = 1'b1;

    always #10 clk = ~clk;

    psr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_imm(cmd_imm),
        .alu_we(alu_we), .alu_val(alu_val), .status(status), .emu(emu),
        .acc_8bit(acc_8bit), .idx_8bit(idx_8bit), .idx_trunc(idx_trunc)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: apply one stimulus and queue the result due after the next edge
    task automatic step(input logic [3:0] op, input logic [7:0] imm,
                        input logic [7:0] we, input logic [7:0] val, input string tag);
        logic [7:0] s;
        logic       e;
        logic       old_x;
        @(negedge clk);
        cmd_op = op; cmd_imm = imm; alu_we = we; alu_val = val;
        s = m_st; e = m_em; old_x = m_st[4];
        case (op)
            4'd1:  s = s & ~imm;
            4'd2:  s = s | imm;
            4'd3:  s[0] = 1'b0;
            4'd4:  s[0] = 1'b1;
            4'd5:  s[2] = 1'b0;
            4'd6:  s[2] = 1'b1;
            4'd7:  s[3] = 1'b0;
            4'd8:  s[3] = 1'b1;
            4'd9:  s[6] = 1'b0;
            4'd10: begin e = m_st[0]; s[0] = m_em; end
            4'd11: s = imm;
            default: s = (s & ~we) | (val & we);
        endcase
        if (e) s[5:4] = 2'b11;
        m_st = s; m_em = e;
        q.push_back('{st: s, em: e, tr: s[4] & ~old_x, tag: tag});
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                chk(it.tag, "status", status, it.st);
                chk(it.tag, "emu", {7'd0, emu}, {7'd0, it.em});
                chk(it.tag, "trunc", {7'd0, idx_trunc}, {7'd0, it.tr});
                chk("R2", "widths", {6'd0, acc_8bit, idx_8bit}, {6'd0, it.st[5], it.st[4]});
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000 && !done) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<5000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset status", status, 8'h34);
        chk("R1", "reset emu", {7'd0, emu}, 8'd1);
        chk("R1", "reset trunc", {7'd0, idx_trunc}, 8'd0);
        rst_n = 1'b1;
        step(4'd10, 8'h00, 8'h00, 8'h00, "R6");   // leave emulation
        step(4'd1,  8'h30, 8'h00, 8'h00, "R3");
        step(4'd2,  8'h10, 8'h00, 8'h00, "R4");   // X rises
        step(4'd0,  8'h00, 8'h00, 8'h00, "R9");   // strobe ends
        step(4'd1,  8'hFF, 8'h00, 8'h00, "R3");
        step(4'd4,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd6,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd8,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd3,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd5,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd7,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd11, 8'h40, 8'h00, 8'h00, "R7");
        step(4'd9,  8'h00, 8'h00, 8'h00, "R5");
        step(4'd0,  8'h00, 8'hC3, 8'h82, "R10");
        step(4'd4,  8'h00, 8'hFF, 8'h00, "R11");
        step(4'd13, 8'h00, 8'h01, 8'h00, "R12");
        step(4'd11, 8'hFF, 8'h00, 8'h00, "R7");   // X rises again
        step(4'd11, 8'h01, 8'h00, 8'h00, "R7");
        step(4'd10, 8'h00, 8'h00, 8'h00, "R8");   // enter emulation
        step(4'd1,  8'h30, 8'h00, 8'h00, "R8");
        step(4'd11, 8'h00, 8'h00, 8'h00, "R8");
        step(4'd0,  8'h00, 8'h30, 8'h00, "R8");
        step(4'd10, 8'h00, 8'h00, 8'h00, "R6");   // back to native
        step(4'd1,  8'h10, 8'h00, 8'h00, "R3");
        step(4'd2,  8'h10, 8'h00, 8'h00, "R9");
        step(4'd0,  8'h00, 8'h00, 8'h00, "R9");
        @(negedge clk);
        cmd_op = '0; alu_we = '0;
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule